// File: doc/BRIEF.md
# Dual-Modulus Feedback Clock Divider

This block divides a fast clock by a programmable ratio N in a PLL feedback path. It uses the pulse-swallow method. A prescaler runs at one of two moduli, a long one and a short one. An M counter counts prescaler terminal counts to mark the end of each output period. An A counter decides how many of those prescaler cycles use the long modulus. With the doubling select clear, the moduli are 7 and 6. With it set, they are 14 and 12, so N doubles for the same M and A.

The M field is 6 bits wide and the A field is 4 bits wide. Each output period takes M+1 prescaler cycles. When A is nonzero, the first A of those cycles are long and the rest are short, which gives N = 6(M+1)+A. When A is zero, every cycle is long and N = 7(M+1).

Settings are picked up only at a period boundary. The block marks the start of each period with a single-cycle pulse. It also provides a near-square feedback clock whose significant edge is chosen by a polarity input. An A value that cannot be honoured is flagged, and the block falls back to the all-long ratio.

Top module: `pulse_swallow_div`

## Requirements
- R1: With dblSel=0 and 1 <= aSel <= mSel+1, the distance between consecutive fbPulse assertions is 6(mSel+1)+aSel cycles.
- R2: With dblSel=0 and aSel=0, the period is 7(mSel+1) cycles.
- R3: With dblSel=1, the period is twice the value given by R1, R2 or R8 for the same mSel and aSel.
- R4: mSel, aSel and dblSel are sampled only at the clock edge that ends a period, and at reset edges. Changing them at any other time does not alter the length of the period in progress.
- R5: fbPulse is high for exactly one cycle, in the first cycle of every period except the first period after reset.
- R6: With fbPol=0, fbClk is high for the first ceil(N/2) cycles of each period and low for the rest, so its rising edge marks the period start.
- R7: With fbPol=1, fbClk is the inverse of the R6 waveform, so its falling edge marks the period start. fbPol acts in the same cycle it changes, with no register in between.
- R8: When aSel > mSel+1 is latched for a period, cfgErr is high for that whole period and the period is 7(mSel+1) cycles (doubled under R3). When the latched setting is valid, cfgErr is low.
- R9: rst is synchronous and active high. While it is asserted, fbPulse is low. The first cycle after release is cycle 0 of a period set by the inputs seen at the last reset edge. That cycle carries no pulse, and the first pulse arrives N cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| mSel | input | 6 | M setting; each period holds mSel+1 prescaler cycles |
| aSel | input | 4 | Number of long prescaler cycles per period; 0 selects all long |
| dblSel | input | 1 | 1 doubles both prescaler moduli |
| fbPol | input | 1 | Feedback edge select: 0 rising, 1 falling |
| fbPulse | output | 1 | One-cycle marker at the start of each period |
| fbClk | output | 1 | Near-square divided clock, polarity per fbPol |
| cfgErr | output | 1 | Latched setting had aSel > mSel+1 |

## Verification
The assertions assume reset is held for at least one clock edge before normal operation, so every counter has been loaded. The single-cycle pulse property depends on N never falling below 6, which is true for every encodable setting. The stimulus never relies on inputs being sampled mid-period. Inputs change only one nanosecond after a rising edge. Error settings such as aSel=7 with mSel=2 are applied on purpose and never produce an out-of-range counter state. A random phase rewrites mSel, aSel and dblSel every five cycles, which tests that only boundary values reach the counters.

// File: rtl/psdiv_pkg.sv
package psdiv_pkg;
  localparam int SHORT_MOD = 6;
  localparam int LONG_MOD  = 7;

  typedef struct packed {
    logic load;     // reload prescaler this edge
    logic start;    // a new output period begins after this edge
    logic useLong;  // modulus for the prescaler cycle being loaded
    logic dbl;      // doubling applies to the loaded modulus
  } divStrobe_t;
endpackage

// File: rtl/psdiv_ctrl.sv
module psdiv_ctrl
  import psdiv_pkg::*;
#(
  parameter int M_W = 6,
  parameter int A_W = 4,
  parameter int N_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [M_W-1:0]   mSel,
  input  logic [A_W-1:0]   aSel,
  input  logic             dblSel,
  input  logic             pTerm,
  output divStrobe_t       divStb,
  output logic [N_W-1:0]   periodLen,
  output logic             cfgErr
);
  localparam int C_W = ((A_W > M_W) ? A_W : M_W) + 1;

  logic [M_W-1:0] cfgM, mCnt;
  logic [A_W-1:0] aCnt, selA;
  logic           cfgDbl, cfgAZero, selErr, wrap, start;
  logic [C_W-1:0] aExt, mPlus;
  logic [N_W-1:0] mPlusN, baseLen;

  // range check of the requested A against M+1
  assign aExt   = C_W'(aSel);
  assign mPlus  = C_W'(mSel) + C_W'(1);
  assign selErr = aExt > mPlus;
  assign selA   = selErr ? '0 : aSel;

  assign wrap  = pTerm && (mCnt == '0);
  assign start = rst || wrap;

  // ratio of the period about to start, used for the square output
  assign mPlusN    = N_W'(mSel) + N_W'(1);
  assign baseLen   = (selA == '0) ? mPlusN * N_W'(LONG_MOD)
                                  : mPlusN * N_W'(SHORT_MOD) + N_W'(selA);
  assign periodLen = dblSel ? (baseLen << 1) : baseLen;

  always_comb begin
    divStb.load    = rst || pTerm;
    divStb.start   = start;
    divStb.dbl     = start ? dblSel : cfgDbl;
    if (start)          divStb.useLong = 1'b1;
    else if (cfgAZero)  divStb.useLong = 1'b1;
    else                divStb.useLong = aCnt > A_W'(1);
  end

  always_ff @(posedge clk) begin
    if (start) begin
      cfgM     <= mSel;
      cfgDbl   <= dblSel;
      cfgAZero <= (selA == '0);
      cfgErr   <= selErr;
      mCnt     <= mSel;
      aCnt     <= selA;
    end else if (pTerm) begin
      mCnt <= mCnt - M_W'(1);
      if (!cfgAZero && aCnt != '0) aCnt <= aCnt - A_W'(1);
    end
  end

  // R1: M counter never runs past the latched M
  p_mcnt_bound_r1: assert property (@(posedge clk) disable iff (rst)
    mCnt <= cfgM);
  // R4: latched settings only move on a period boundary
  p_cfg_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !divStb.start |=> $stable({cfgM, cfgDbl, cfgAZero, cfgErr}));
  // R8: an error setting always runs in all-long mode
  p_err_fallback_r8: assert property (@(posedge clk) disable iff (rst)
    cfgErr |-> (cfgAZero && aCnt == '0));
endmodule

// File: rtl/psdiv_dp.sv
module psdiv_dp
  import psdiv_pkg::*;
#(
  parameter int N_W = 10
) (
  input  logic           clk,
  input  logic           rst,
  input  divStrobe_t     divStb,
  input  logic [N_W-1:0] periodLen,
  input  logic           fbPol,
  output logic           pTerm,
  output logic           fbPulse,
  output logic           fbClk
);
  localparam int P_W = $clog2(2 * LONG_MOD + 1);

  logic [P_W-1:0] pCnt, baseMod, modVal;
  logic [N_W-1:0] posCnt, hiLen;
  logic [N_W:0]   lenP1;
  logic           pulseQ, rawHi;

  assign baseMod = divStb.useLong ? P_W'(LONG_MOD) : P_W'(SHORT_MOD);
  assign modVal  = divStb.dbl ? (baseMod << 1) : baseMod;
  assign pTerm   = (pCnt == '0);
  assign lenP1   = {1'b0, periodLen} + (N_W+1)'(1);

  always_ff @(posedge clk) begin
    if (divStb.load) pCnt <= modVal - P_W'(1);
    else             pCnt <= pCnt - P_W'(1);
    if (divStb.start) begin
      posCnt <= '0;
      hiLen  <= lenP1[N_W:1];
    end else begin
      posCnt <= posCnt + N_W'(1);
    end
    pulseQ <= divStb.start && !rst;
  end

  assign rawHi   = posCnt < hiLen;
  assign fbClk   = rawHi ^ fbPol;
  assign fbPulse = pulseQ;

  // R5: the marker sits in the first cycle of a period and lasts one cycle
  p_pulse_at_start_r5: assert property (@(posedge clk) disable iff (rst)
    fbPulse |-> (posCnt == '0));
  p_pulse_single_r5: assert property (@(posedge clk) disable iff (rst)
    fbPulse |=> !fbPulse);
  // R6: the unadjusted square wave only rises at a period start
  p_rise_at_start_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(rawHi) |-> (posCnt == '0));
endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div
  import psdiv_pkg::*;
#(
  parameter int M_W = 6,
  parameter int A_W = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [M_W-1:0] mSel,
  input  logic [A_W-1:0] aSel,
  input  logic           dblSel,
  input  logic           fbPol,
  output logic           fbPulse,
  output logic           fbClk,
  output logic           cfgErr
);
  localparam int N_W = $clog2(2 * LONG_MOD * (2 ** M_W) + 1);

  divStrobe_t     divStb;
  logic [N_W-1:0] periodLen;
  logic           pTerm;

  psdiv_ctrl #(.M_W(M_W), .A_W(A_W), .N_W(N_W)) ctrl_i (
    .clk(clk), .rst(rst), .mSel(mSel), .aSel(aSel), .dblSel(dblSel),
    .pTerm(pTerm), .divStb(divStb), .periodLen(periodLen), .cfgErr(cfgErr)
  );

  psdiv_dp #(.N_W(N_W)) dp_i (
    .clk(clk), .rst(rst), .divStb(divStb), .periodLen(periodLen),
    .fbPol(fbPol), .pTerm(pTerm), .fbPulse(fbPulse), .fbClk(fbClk)
  );
endmodule

// File: tb/pulse_swallow_div_tb_top.sv
`timescale 1ns/1ps
module pulse_swallow_div_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic [5:0] mSel;
  logic [3:0] aSel;
  logic       dblSel, fbPol;
  logic       fbPulse, fbClk, cfgErr;

  pulse_swallow_div dut_i (
    .clk(clk), .rst(rst), .mSel(mSel), .aSel(aSel), .dblSel(dblSel),
    .fbPol(fbPol), .fbPulse(fbPulse), .fbClk(fbClk), .cfgErr(cfgErr)
  );

  always #2 clk = ~clk;  // 250 MHz

  int    vecs = 0, errs = 0, cyc = 0, lastMark = 0;
  int    mPos = 0, mCurN = 7, mPrevN = 7;
  bit    mErr = 0, mPulse = 0, mInReset = 1, seenEdge = 0;
  string mCurTag = "R9", mPrevTag = "R9", phase = "";

  function automatic int expN(int m, int a, bit d);
    int n;
    if (a == 0 || a > m + 1) n = 7 * (m + 1);
    else                     n = 6 * (m + 1) + a;
    return d ? 2 * n : n;
  endfunction

  function automatic string tagOf(int m, int a, bit d);
    if (phase != "") return phase;
    if (a > m + 1)   return "R8";
    if (d)           return "R3";
    if (a == 0)      return "R2";
    return "R1";
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: got %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // behavioural reference: position in period and latched ratio
  always @(posedge clk) begin
    cyc++;
    seenEdge = 1;
    if (rst) begin
      mPos = 0;
      mCurN = expN(mSel, aSel, dblSel);
      mErr = (aSel > mSel + 1);
      mCurTag = (phase != "") ? phase : "R9";
      mPulse = 0;
      lastMark = cyc;
    end else if (mPos == mCurN - 1) begin
      mPrevN = mCurN;
      mPrevTag = mCurTag;
      mPos = 0;
      mCurN = expN(mSel, aSel, dblSel);
      mErr = (aSel > mSel + 1);
      mCurTag = tagOf(mSel, aSel, dblSel);
      mPulse = 1;
    end else begin
      mPos++;
      mPulse = 0;
    end
    mInReset = rst;
  end

  always @(negedge clk) begin
    if (seenEdge) begin
      if (mInReset) begin
        chk(fbPulse == 1'b0, "R9", fbPulse, 0);
      end else begin
        bit expClk;
        expClk = (mPos < (mCurN + 1) / 2) ^ fbPol;
        chk(fbPulse == mPulse, "R5", fbPulse, mPulse);
        chk(fbClk == expClk, fbPol ? "R7" : "R6", fbClk, expClk);
        chk(cfgErr == mErr, "R8", cfgErr, mErr);
        if (fbPulse) begin
          chk(cyc - lastMark == mPrevN, mPrevTag, cyc - lastMark, mPrevN);
          lastMark = cyc;
        end
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 150000) begin
      vecs++; errs++;
      $display("FAIL watchdog (all requirements): cycles %0d expected below %0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  int prevSetN = 7;
  task automatic hold(int m, int a, bit d, bit p);
    int n;
    @(posedge clk); #1;
    mSel = 6'(m); aSel = 4'(a); dblSel = d; fbPol = p;
    n = expN(m, a, d);
    repeat (prevSetN + 2 * n + 4) @(posedge clk);
    prevSetN = n;
  endtask

  initial begin
    rst = 1; mSel = 6'd1; aSel = 4'd1; dblSel = 0; fbPol = 0;
    repeat (4) @(posedge clk);
    #1 rst = 0;
    repeat (40) @(posedge clk);
    prevSetN = 13;
    // R1 sweep
    hold(1, 2, 0, 0);  hold(5, 3, 0, 0);  hold(5, 6, 0, 0);
    hold(0, 1, 0, 0);  hold(63, 15, 0, 0); hold(20, 1, 0, 1);
    // R2 sweep
    hold(0, 0, 0, 0);  hold(7, 0, 0, 1);  hold(63, 0, 0, 0);
    // R3 doubled
    hold(1, 1, 1, 0);  hold(4, 0, 1, 1);  hold(63, 0, 1, 0); hold(9, 10, 1, 0);
    // R8 invalid A
    hold(2, 7, 0, 0);  hold(0, 2, 0, 1);  hold(3, 15, 1, 0); hold(1, 1, 0, 0);
    // R4 inputs churn mid-period
    phase = "R4";
    for (int i = 0; i < 300; i++) begin
      @(posedge clk); #1;
      mSel = 6'($urandom_range(0, 20));
      aSel = 4'($urandom_range(0, 15));
      dblSel = 1'($urandom_range(0, 1));
      fbPol = 1'($urandom_range(0, 1));
      repeat (4) @(posedge clk);
    end
    phase = "";
    hold(3, 2, 0, 0);
    // R9 reset in mid-period
    @(posedge clk); #1 rst = 1; mSel = 6'd2; aSel = 4'd3; dblSel = 0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    repeat (100) @(posedge clk);
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule